// File: doc/BRIEF.md
# Character Stream Text Console Writer

This block sits between a byte stream and a register-addressed character screen of 80 columns by 25 rows. Bytes arrive on a valid/ready input. The block tracks a cursor of its own and turns each byte into zero or more cell writes on the screen buffer port. Printable bytes are stored at the cursor, which then moves right. Carriage return, line feed and backspace only move the cursor. Any other byte is taken and dropped.

When the cursor would move below the bottom row, it stays on that row and the block scrolls the screen. The scroll reads every cell of rows 1 to 24 through a read port that has one cycle of latency. It writes each cell back one row higher, then fills the bottom row with spaces. Every cell write puts the column and row on the address outputs one cycle before the cycle in which the strobe and the character appear. The input is held off while a write or a scroll is in progress.

Top module: `text_console_writer`

## Requirements
- R1: Every cell write (wr_en high) targets a column in 0..79 and a row in 0..24.
- R2: In the cycle before wr_en is high, wr_col and wr_row already hold the values they have while wr_en is high. wr_char is valid in the strobe cycle. A printable byte accepted at a clock edge gives its strobe in the second cycle after that edge.
- R3: A byte from 0x20 to 0x7E is written at the cursor, and then the column increases by one. Writing at column 79 moves the cursor to column 0 of the next row.
- R4: Carriage return (0x0D) sets the column to 0. It keeps the row and makes no write.
- R5: Line feed (0x0A) moves the cursor one row down. It keeps the column and makes no write.
- R6: Backspace (0x08) moves the cursor one column left and makes no write. At column 0 it has no effect.
- R7: Any other byte (0x00..0x1F apart from the three control codes, and 0x7F..0xFF) is accepted and makes no write. The cursor does not move.
- R8: A line feed on row 24, or a wrap from column 79 on row 24, leaves the cursor on row 24 and starts a scroll. The column is kept for a line feed and becomes 0 for a wrap. For each destination row 0..23 and column 0..79 in turn, the scroll reads (column, row+1) with rd_en. In the next cycle it writes rd_char to (column, row). It then writes 0x20 to every column of row 24, in rising column order.
- R9: in_ready is low from the acceptance of a printable byte, or of a byte that starts a scroll, until its writes have ended. After any other byte, in_ready stays high.
- R10: After reset the cursor is at column 0, row 0, in_ready is high, and wr_en and rd_en are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte is valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block can take a byte this cycle |
| wr_en | output | 1 | Cell write strobe |
| wr_col | output | 7 | Target column of the cell write |
| wr_row | output | 5 | Target row of the cell write |
| wr_char | output | 8 | Character written, valid with wr_en |
| rd_en | output | 1 | Cell read request used by the scroll |
| rd_col | output | 7 | Column to read |
| rd_row | output | 5 | Row to read |
| rd_char | input | 8 | Cell content, valid the cycle after rd_en |

## Verification
The bench goes after the corners where cursor arithmetic often goes wrong. A backspace at column 0 that underflowed would send the next character to column 127. A carriage return that also cleared the row would land text on row 0. A line feed that reset the column would misplace the next character. It drives a wrap at column 79 and both kinds of bottom-row overflow, one by line feed and one by wrap. A design that lets the row reach 25 would write off screen. One that copies rows in the wrong direction, or mistimes the read latency, would leave the rows duplicated or shifted, and the final comparison of the whole screen shows this. Bytes just outside the printable range (0x1F, 0x7F, 0xFF) must produce no write.

// File: rtl/tcw_pkg.sv
package tcw_pkg;

  typedef enum logic [2:0] {
    K_DROP, K_PRINT, K_CR, K_LF, K_BS
  } kind_t;

  typedef enum logic [2:0] {
    CUR_HOLD, CUR_HOME, CUR_BACK, CUR_DOWN, CUR_STEP
  } cur_cmd_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_DATA, ST_CPY_RD, ST_CPY_WR, ST_BLK_ADDR, ST_BLK_WR
  } state_t;

  localparam logic [7:0] CH_BS    = 8'h08;
  localparam logic [7:0] CH_LF    = 8'h0A;
  localparam logic [7:0] CH_CR    = 8'h0D;
  localparam logic [7:0] CH_SPACE = 8'h20;
  localparam logic [7:0] CH_TILDE = 8'h7E;

  // Sort an incoming byte into the action it calls for.
  function automatic kind_t classify(input logic [7:0] b);
    if (b >= CH_SPACE && b <= CH_TILDE) return K_PRINT;
    if (b == CH_CR) return K_CR;
    if (b == CH_LF) return K_LF;
    if (b == CH_BS) return K_BS;
    return K_DROP;
  endfunction

endpackage

// File: rtl/tcw_decode.sv
module tcw_decode
  import tcw_pkg::*;
(
  input  logic [7:0] code,
  output kind_t      kind
);
  always_comb kind = classify(code);
endmodule

// File: rtl/tcw_cursor.sv
module tcw_cursor
  import tcw_pkg::*;
#(
  parameter int COLS = 80,
  parameter int ROWS = 25,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cur_cmd_t      cmd,
  output logic [CW-1:0] col,
  output logic [RW-1:0] row,
  output logic          overflow
);
  localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);
  localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

  logic at_last_col, at_last_row;
  assign at_last_col = (col == LAST_COL);
  assign at_last_row = (row == LAST_ROW);

  // A move below the bottom row requests a scroll instead.
  always_comb
    overflow = at_last_row &&
               ((cmd == CUR_DOWN) || (cmd == CUR_STEP && at_last_col));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col <= '0;
      row <= '0;
    end else begin
      case (cmd)
        CUR_HOME: col <= '0;
        CUR_BACK: if (col != '0) col <= col - 1'b1;
        CUR_DOWN: if (!at_last_row) row <= row + 1'b1;
        CUR_STEP: begin
          if (!at_last_col) begin
            col <= col + 1'b1;
          end else begin
            col <= '0;
            if (!at_last_row) row <= row + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tcw_scan.sv
module tcw_scan #(
  parameter int COLS = 80,
  parameter int ROWS = 25,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          step,
  output logic [CW-1:0] col,
  output logic [RW-1:0] row,
  output logic          copy_end,
  output logic          blank_end
);
  localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);
  localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);
  localparam logic [RW-1:0] LAST_SRC = RW'(ROWS - 2);

  assign copy_end  = (row == LAST_SRC) && (col == LAST_COL);
  assign blank_end = (row == LAST_ROW) && (col == LAST_COL);

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      col <= '0;
      row <= '0;
    end else if (step) begin
      if (col != LAST_COL) begin
        col <= col + 1'b1;
      end else begin
        col <= '0;
        row <= blank_end ? '0 : row + 1'b1;
      end
    end
  end
endmodule

// File: rtl/text_console_writer.sv
module text_console_writer
  import tcw_pkg::*;
#(
  parameter int COLS = 80,
  parameter int ROWS = 25,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  output logic          wr_en,
  output logic [CW-1:0] wr_col,
  output logic [RW-1:0] wr_row,
  output logic [7:0]    wr_char,
  output logic          rd_en,
  output logic [CW-1:0] rd_col,
  output logic [RW-1:0] rd_row,
  input  logic [7:0]    rd_char
);
  state_t        state, nstate;
  kind_t         kind;
  cur_cmd_t      cur_cmd;
  logic [CW-1:0] cur_col, scan_col;
  logic [RW-1:0] cur_row, scan_row;
  logic          overflow, copy_end, blank_end, scan_step;
  logic [7:0]    char_q;

  // Named events for the checker.
  logic accept, scroll_start, cell_write;

  assign in_ready     = (state == ST_IDLE);
  assign accept       = in_valid && in_ready;
  assign scroll_start = overflow;

  tcw_decode u_dec (.code(in_data), .kind(kind));

  always_comb begin
    cur_cmd = CUR_HOLD;
    if (accept) begin
      case (kind)
        K_CR:    cur_cmd = CUR_HOME;
        K_LF:    cur_cmd = CUR_DOWN;
        K_BS:    cur_cmd = CUR_BACK;
        default: cur_cmd = CUR_HOLD;
      endcase
    end else if (state == ST_DATA) begin
      cur_cmd = CUR_STEP;
    end
  end

  tcw_cursor #(.COLS(COLS), .ROWS(ROWS)) u_cur (
    .clk(clk), .rst_n(rst_n), .cmd(cur_cmd),
    .col(cur_col), .row(cur_row), .overflow(overflow)
  );

  assign scan_step = (state == ST_CPY_WR) || (state == ST_BLK_WR);

  tcw_scan #(.COLS(COLS), .ROWS(ROWS)) u_scan (
    .clk(clk), .rst_n(rst_n), .start(scroll_start), .step(scan_step),
    .col(scan_col), .row(scan_row), .copy_end(copy_end), .blank_end(blank_end)
  );

  always_comb begin
    nstate = state;
    case (state)
      ST_IDLE: begin
        if (accept) begin
          if (kind == K_PRINT) nstate = ST_ADDR;
          else if (overflow)   nstate = ST_CPY_RD;
        end
      end
      ST_ADDR:     nstate = ST_DATA;
      ST_DATA:     nstate = overflow ? ST_CPY_RD : ST_IDLE;
      ST_CPY_RD:   nstate = ST_CPY_WR;
      ST_CPY_WR:   nstate = copy_end ? ST_BLK_ADDR : ST_CPY_RD;
      ST_BLK_ADDR: nstate = ST_BLK_WR;
      ST_BLK_WR:   nstate = blank_end ? ST_IDLE : ST_BLK_ADDR;
      default:     nstate = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      char_q <= CH_SPACE;
    end else begin
      state <= nstate;
      if (accept) char_q <= in_data;
    end
  end

  assign cell_write = (state == ST_DATA) || (state == ST_CPY_WR) ||
                      (state == ST_BLK_WR);
  assign wr_en = cell_write;

  always_comb begin
    if (state == ST_IDLE || state == ST_ADDR || state == ST_DATA) begin
      wr_col = cur_col;
      wr_row = cur_row;
    end else begin
      wr_col = scan_col;
      wr_row = scan_row;
    end
    case (state)
      ST_DATA:   wr_char = char_q;
      ST_CPY_WR: wr_char = rd_char;
      default:   wr_char = CH_SPACE;
    endcase
  end

  assign rd_en  = (state == ST_CPY_RD);
  assign rd_col = scan_col;
  assign rd_row = scan_row + 1'b1;
endmodule

// File: rtl/tcw_checker.sv
module tcw_checker #(
  parameter int COLS = 80,
  parameter int ROWS = 25,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          accept,
  input logic [7:0]    in_data,
  input logic          wr_en,
  input logic [CW-1:0] wr_col,
  input logic [RW-1:0] wr_row,
  input logic          rd_en,
  input logic [CW-1:0] rd_col,
  input logic [RW-1:0] rd_row,
  input logic [CW-1:0] cur_col,
  input logic [RW-1:0] cur_row,
  input logic          scroll_start
);
  assert_cell_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_col) < COLS) && (int'(wr_row) < ROWS));

  assert_addr_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $stable(wr_col) && $stable(wr_row));

  assert_cr_home_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_data == 8'h0D |=> cur_col == '0 && cur_row == $past(cur_row));

  assert_bs_left_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_data == 8'h08 && cur_col == '0 |=> cur_col == '0 && $stable(cur_row));

  assert_drop_no_move_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_data == 8'h7F |=> $stable(cur_col) && $stable(cur_row) && in_ready);

  assert_copy_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> wr_en && wr_col == $past(rd_col) && wr_row == $past(rd_row) - 1'b1);

  assert_scroll_bottom_R8: assert property (@(posedge clk) disable iff (!rst_n)
    scroll_start |=> int'(cur_row) == ROWS - 1);

  assert_busy_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !in_ready);
endmodule

bind text_console_writer tcw_checker #(.COLS(COLS), .ROWS(ROWS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .accept(accept),
  .in_data(in_data), .wr_en(wr_en), .wr_col(wr_col), .wr_row(wr_row),
  .rd_en(rd_en), .rd_col(rd_col), .rd_row(rd_row),
  .cur_col(cur_col), .cur_row(cur_row), .scroll_start(scroll_start)
);

// File: tb/text_console_writer_test.sv
`timescale 1ns/1ps
module text_console_writer_test;
  localparam int NC = 80;
  localparam int NR = 25;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, wr_en, rd_en;
  logic [6:0] wr_col, rd_col;
  logic [4:0] wr_row, rd_row;
  logic [7:0] wr_char;
  logic [7:0] rd_char = 8'h00;

  always #2.5 clk = ~clk;

  text_console_writer uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .wr_en(wr_en), .wr_col(wr_col), .wr_row(wr_row),
    .wr_char(wr_char), .rd_en(rd_en), .rd_col(rd_col), .rd_row(rd_row),
    .rd_char(rd_char)
  );

  // Screen buffer seen by the design: synchronous read, one cycle latency.
  logic [7:0] mem [NC*NR];
  always @(posedge clk) begin
    if (wr_en) mem[int'(wr_row)*NC + int'(wr_col)] <= wr_char;
    if (rd_en) rd_char <= mem[int'(rd_row)*NC + int'(rd_col)];
  end

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Model of the screen and cursor, built from the requirements.
  logic [7:0]  exp_scr [NC*NR];
  logic [19:0] expq [$];  // {col[6:0], row[4:0], char[7:0]}
  int mc = 0;
  int mr = 0;

  task automatic push_write(input int c, input int r, input logic [7:0] ch);
    expq.push_back({7'(c), 5'(r), ch});
    exp_scr[r*NC + c] = ch;
  endtask

  task automatic model_scroll();
    for (int r = 0; r < NR - 1; r++)
      for (int c = 0; c < NC; c++)
        push_write(c, r, exp_scr[(r+1)*NC + c]);
    for (int c = 0; c < NC; c++) push_write(c, NR - 1, 8'h20);
  endtask

  // Driver: model the byte, present it, then check in_ready behaviour (R9).
  task automatic send(input logic [7:0] b);
    bit busy = 0;
    if (b >= 8'h20 && b <= 8'h7E) begin
      push_write(mc, mr, b);
      busy = 1;
      if (mc < NC - 1) mc++;
      else begin
        mc = 0;
        if (mr < NR - 1) mr++; else model_scroll();
      end
    end else if (b == 8'h0D) begin
      mc = 0;
    end else if (b == 8'h0A) begin
      if (mr < NR - 1) mr++; else begin model_scroll(); busy = 1; end
    end else if (b == 8'h08) begin
      if (mc > 0) mc--;
    end
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == !busy, "R9 in_ready after acceptance", int'(in_ready), int'(!busy));
  endtask

  // Monitor: compare every write against the queue; address must lead strobe (R2).
  logic [6:0] prev_col;
  logic [4:0] prev_row;
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_en) begin
        check(wr_col == prev_col && wr_row == prev_row, "R2 address set before strobe",
              {prev_col, prev_row}, {wr_col, wr_row});
        if (expq.size() == 0) begin
          check(0, "R7 unexpected write", {wr_col, wr_row, wr_char}, 0);
        end else begin
          logic [19:0] e;
          e = expq.pop_front();
          check({wr_col, wr_row, wr_char} == e, "R1 R3 R8 cell write {col,row,char}",
                {wr_col, wr_row, wr_char}, e);
        end
      end
      prev_col = wr_col;
      prev_row = wr_row;
    end
  end

  task automatic drain();
    repeat (3) @(negedge clk);
    while (!in_ready) @(negedge clk);
    repeat (2) @(negedge clk);
    check(expq.size() == 0, "R8 all expected writes seen", expq.size(), 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < NC*NR; i++) begin
      mem[i] = 8'h00;
      exp_scr[i] = 8'h00;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check(in_ready == 1'b1, "R10 in_ready after reset", int'(in_ready), 1);
    check(wr_en == 1'b0 && rd_en == 1'b0, "R10 no strobes after reset", {wr_en, rd_en}, 0);

    // R10/R3: first characters land at origin, cursor advances
    send("H"); send("i");
    // R4: carriage return keeps the row
    send(8'h0D); send("A");
    // R5: line feed keeps the column
    send(8'h0A); send("B");
    // R6: backspace, then backspace at column 0
    send(8'h08); send("C");
    send(8'h0D); send(8'h08); send("D");
    // R7: bytes outside the printable range are dropped
    send(8'h7F); send(8'h00); send(8'h1F); send(8'h1B); send(8'hC1); send(8'hFF);
    // R3: range edges 0x7E and 0x20
    send(8'h7E); send(8'h20);
    drain();

    // R3: wrap from column 79 to next row
    send(8'h0D); send(8'h0A);
    for (int i = 0; i < NC; i++) send(8'(8'h61 + (i % 26)));
    send("Z");
    drain();

    // R8: line feed on the bottom row scrolls
    while (mr < NR - 1) send(8'h0A);
    send(8'h0A);
    send("q");
    drain();

    // R8: wrap on the bottom row scrolls, column goes to 0
    while (mc != 0) send(8'(8'h30 + (mc % 10)));
    send("w");
    drain();

    begin
      int bad = 0;
      for (int i = 0; i < NC*NR; i++) if (mem[i] !== exp_scr[i]) bad++;
      check(bad == 0, "R8 final screen contents (mismatching cells)", bad, 0);
    end
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", 150000);
    summary();
  end
endmodule